// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block runs next to an I2C slave bit engine. It answers the SMBus alert response protocol for a device that has an alert pending. After a START it collects the first byte on the bus. If that byte is the alert response address with the read bit set and the device's alert is pending, the block acknowledges the byte. It then shifts out the device's own 7-bit address followed by one comparator status bit. SDA is only ever pulled low or released, so several responders can answer at once. Bitwise wired-AND arbitration makes the lowest address win. Only the winner pulses a clear to its alert latch. A loser keeps its alert and waits for the master to repeat the alert response read.

Raw SCL and SDA pass through synchronisers. Bus edges, START and STOP are detected on the system clock. An idle-bus timer returns the block to idle when a transfer stalls. Normal register access and clock stretching belong to other logic.

The control is a seven-state machine. The states and their transitions are:

- **ST_IDLE**: leaves only on START.
- **ST_RX_ADDR**: samples 8 bits on SCL rising edges, then goes to ST_ADDR_END.
- **ST_ADDR_END**: on the next SCL fall, goes to ST_ACK if the byte matches and the alert is pending, otherwise to ST_PARK.
- **ST_ACK**: holds SDA low through the ninth clock and moves to ST_TX on its falling edge.
- **ST_TX**: drives 8 response bits, one per SCL low phase. Lost arbitration sends it to ST_PARK. After the eighth bit it moves to ST_MACK.
- **ST_MACK**: waits for the master's acknowledge clock. Its falling edge issues the clear and moves to ST_PARK.
- **ST_PARK**: waits silently.

From any state, START moves to ST_RX_ADDR, and STOP or a timeout moves to ST_IDLE.

Top module: `smbus_alert_responder`

## Requirements
- R1: After reset, sda_pull and alert_clear are both 0.
- R2: The block pulls SDA low during the ninth clock only when the first byte after START equals 8'b0001_1001 and alert_pending is 1. Any other byte, or alert_pending at 0, leaves SDA released for the rest of the transfer and gives no clear.
- R3: After its acknowledge, the block sends {dev_addr[6:0], alert_status}, most significant bit first, one bit per SCL low phase. A 0 is sent as a pull-low and a 1 as release. sda_pull never changes while SCL is high, except on timeout.
- R4: If the block releases SDA for a 1 but samples 0 while SCL is high, it stops driving for the rest of the transfer and gives no clear. With several responders, the lowest address is what the master reads.
- R5: The eighth response bit is alert_status, latched when the acknowledge starts: 1 for a high-threshold crossing, 0 for a low-threshold crossing.
- R6: alert_clear is a single-cycle pulse, issued once after all 8 response bits are sent without loss and the following acknowledge clock (ACK or NACK) has ended. It never occurs before that clock falls.
- R7: A STOP returns the block to idle. A START from any state, including a repeated START without STOP, begins a new address byte.
- R8: With no SCL or SDA edge for TIMEOUT_CYC system clocks outside idle, the block returns to idle and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| dev_addr | input | ADDR_W | Device's own slave address |
| alert_pending | input | 1 | Alert latch is set |
| alert_status | input | 1 | Comparator status: 1 high, 0 low threshold |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| alert_clear | output | 1 | One-cycle pulse that clears the alert latch |

## Verification
The assertions check on every cycle that:

- sda_pull changes only while the synchronised SCL is low, or on timeout;
- a lost bit forces an exit from transmission;
- STOP and timeout always land in idle;
- alert_clear lasts one cycle and follows only the master-acknowledge state.

Only the bench scenarios can show that:

- the bytes the master reads equal the wired-AND arbitration result against a rival responder;
- the lowest address wins;
- a status bit lands in the last position;
- a stalled bus releases SDA after the timeout;
- a repeated START after a lost round yields a win.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_ADDR_END,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_PARK
    } sar_state_e;

    // alert response address (0001100) with read bit set
    localparam logic [7:0] ARA_READ_BYTE = 8'b0001_1001;
endpackage

// File: rtl/sar_bus_sync.sv
module sar_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_edge
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;
    logic          scl_q;
    logic          sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[LAST-1:0], scl_in};
                    sda_ff <= {sda_ff[LAST-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[LAST];
            sda_q <= sda_ff[LAST];
        end
    end

    assign scl_lvl   = scl_ff[LAST];
    assign sda_lvl   = sda_ff[LAST];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    assign bus_edge  = (scl_lvl ^ scl_q) | (sda_lvl ^ sda_q);
endmodule

// File: rtl/sar_idle_timer.sv
module sar_idle_timer #(
    parameter int LIMIT = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic activity,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          at_limit;

    assign at_limit = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            expired <= active & ~activity & at_limit;
            if (!active || activity || at_limit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbus_alert_responder.sv
module smbus_alert_responder #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              alert_pending,
    input  logic              alert_status,
    output logic              sda_pull,
    output logic              alert_clear
);
    import sar_pkg::*;

    localparam int BYTE_W = 8;
    localparam int RESP_W = ADDR_W + 1;
    localparam int MAX_W  = (RESP_W > BYTE_W) ? RESP_W : BYTE_W;
    localparam int CNT_W  = $clog2(MAX_W);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det, bus_edge;
    logic tmo_hit;

    sar_state_e          state, nxt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   rx_byte;
    logic [RESP_W-1:0]   tx_word;
    logic                cur_bit;
    logic                lost;

    sar_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_edge  (bus_edge)
    );

    sar_idle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state != ST_IDLE),
        .activity (bus_edge),
        .expired  (tmo_hit)
    );

    assign cur_bit = tx_word[RESP_W-1];
    assign lost    = scl_rise & cur_bit & ~sda_lvl;

    // next-state logic
    always_comb begin
        nxt = state;
        if (tmo_hit) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_RX_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_RX_ADDR:  if (scl_rise && bit_cnt == CNT_W'(BYTE_W - 1)) nxt = ST_ADDR_END;
                ST_ADDR_END: if (scl_fall)
                                 nxt = (rx_byte == ARA_READ_BYTE && alert_pending) ? ST_ACK : ST_PARK;
                ST_ACK:      if (scl_fall) nxt = ST_TX;
                ST_TX: begin
                    if (lost)                                          nxt = ST_PARK;
                    else if (scl_fall && bit_cnt == CNT_W'(RESP_W - 1)) nxt = ST_MACK;
                end
                ST_MACK:     if (scl_fall) nxt = ST_PARK;
                ST_PARK:     nxt = ST_PARK;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath: bit counter, receive and transmit shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_byte <= '0;
            tx_word <= '1;
        end else if (start_det) begin
            bit_cnt <= '0;
            rx_byte <= '0;
        end else begin
            if (state == ST_RX_ADDR && scl_rise) begin
                rx_byte <= {rx_byte[BYTE_W-2:0], sda_lvl};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_ADDR_END && nxt == ST_ACK) begin
                tx_word <= {dev_addr, alert_status};
                bit_cnt <= '0;
            end
            if (state == ST_TX && scl_fall && nxt == ST_TX) begin
                tx_word <= {tx_word[RESP_W-2:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ACK:  sda_pull = 1'b1;
            ST_TX:   sda_pull = ~cur_bit;
            default: sda_pull = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alert_clear <= 1'b0;
        else        alert_clear <= (state == ST_MACK) && (nxt == ST_PARK);
    end
endmodule

// File: rtl/sar_checker.sv
module sar_checker (
    input logic                clk,
    input logic                rst_n,
    input sar_pkg::sar_state_e state,
    input logic                scl_lvl,
    input logic                sda_lvl,
    input logic                scl_rise,
    input logic                stop_det,
    input logic                tmo_hit,
    input logic                sda_pull,
    input logic                alert_clear
);
    import sar_pkg::*;

    // R3: the open-drain enable only moves while SCL is low (timeout excepted)
    a_r3_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> (!$past(scl_lvl) || $past(tmo_hit)));

    // R4: a released 1 that reads back 0 ends transmission
    a_r4_lost_leaves_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && scl_rise && !sda_pull && !sda_lvl) |=> (state != ST_TX));

    // R6: clear is one cycle long
    a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clear |=> !alert_clear);

    // R6: clear only follows the master-acknowledge state
    a_r6_clear_after_mack: assert property (@(posedge clk) disable iff (!rst_n)
        alert_clear |-> ($past(state) == ST_MACK));

    // R7: STOP returns to idle
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R8: timeout returns to idle with SDA released
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> (state == ST_IDLE && !sda_pull));
endmodule

bind smbus_alert_responder sar_checker u_sar_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .stop_det    (stop_det),
    .tmo_hit     (tmo_hit),
    .sda_pull    (sda_pull),
    .alert_clear (alert_clear)
);

// File: tb/test_smbus_alert_responder.sv
module test_smbus_alert_responder;
    localparam int TMO = 400;
    localparam int Q   = 10;
    localparam int H   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       r_pull = 1'b0;
    logic [6:0] dev = 7'h20;
    logic       stat = 1'b0;
    logic       pend = 1'b1;
    logic       dut_pull;
    logic       dut_clear;
    logic       sda_line;
    int         errors = 0;
    int         checks = 0;
    int         clr_cnt = 0;
    bit         done = 1'b0;

    assign sda_line = m_sda & ~r_pull & ~dut_pull;

    always #2 clk = ~clk;

    smbus_alert_responder #(.ADDR_W(7), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) i_smbus_alert_responder (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .dev_addr      (dev),
        .alert_pending (pend),
        .alert_status  (stat),
        .sda_pull      (dut_pull),
        .alert_clear   (dut_clear)
    );

    always @(posedge clk) if (dut_clear) clr_cnt <= clr_cnt + 1;

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ack(input logic [7:0] b, input logic p);
        return (b == 8'b0001_1001) && p;
    endfunction

    function automatic logic [7:0] exp_read(input bit part, input bit rv, input logic [7:0] db, input logic [7:0] rb);
        if (part && rv) return (db < rb) ? db : rb;
        if (part)       return db;
        if (rv)         return rb;
        return 8'hFF;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wcyc(Q);
        scl = 1'b1;   wcyc(H/2);
        m_sda = 1'b0; wcyc(H/2);
        scl = 1'b0;   wcyc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wcyc(Q);
        scl = 1'b1;   wcyc(Q);
        m_sda = 1'b1; wcyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wcyc(Q);
            scl = 1'b1;   wcyc(H);
            scl = 1'b0;   wcyc(Q);
        end
        m_sda = 1'b1; wcyc(Q);
        scl = 1'b1;   wcyc(H/2);
        ack = ~sda_line;
        wcyc(H/2);
        scl = 1'b0;   wcyc(Q);
    endtask

    task automatic read_resp(input bit rv, input logic [7:0] rb, input bit mack,
                             output logic [7:0] rd, output bit early);
        bit   r_act;
        logic s1, s2;
        int   c0;
        r_act = rv;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            r_pull = r_act & ~rb[i];
            wcyc(Q);
            scl = 1'b1; wcyc(H/2);
            s1 = sda_line; wcyc(H/2);
            s2 = sda_line;
            chk(s1 == s2, "R3", "SDA stable while SCL high", int'(s2), int'(s1));
            rd[i] = s1;
            if (r_act && rb[i] && !s1) r_act = 1'b0;
            scl = 1'b0; wcyc(Q);
        end
        r_pull = 1'b0;
        c0 = clr_cnt;
        m_sda = mack ? 1'b0 : 1'b1; wcyc(Q);
        scl = 1'b1; wcyc(H);
        early = (clr_cnt != c0);
        scl = 1'b0; wcyc(Q);
        m_sda = 1'b1;
    endtask

    task automatic run_txn(input logic [7:0] ab, input bit rv, input logic [7:0] rb,
                           input bit mack, input bit do_stop, input string tag);
        bit         ack, part, win, early;
        logic [7:0] rd, db, er;
        int         c0;
        bus_start();
        send_byte(ab, ack);
        part = exp_ack(ab, pend);
        chk(ack == part, "R2", {tag, " address acknowledge"}, int'(ack), int'(part));
        db = {dev, stat};
        er = exp_read(part, rv, db, rb);
        win = part && (!rv || db < rb);
        c0 = clr_cnt;
        read_resp(rv, rb, mack, rd, early);
        chk(rd == er, part ? (rv ? "R4" : "R3") : "R2", {tag, " response byte"}, int'(rd), int'(er));
        chk(!early, "R6", {tag, " no clear before ack clock ends"}, int'(early), 0);
        chk((clr_cnt - c0) == int'(win), win ? "R6" : "R4", {tag, " clear count"}, clr_cnt - c0, int'(win));
        if (do_stop) bus_stop();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wcyc(3);
        // R1: reset state
        chk(dut_pull == 1'b0, "R1", "sda_pull after reset", int'(dut_pull), 0);
        chk(dut_clear == 1'b0, "R1", "alert_clear after reset", int'(dut_clear), 0);
        rst_n = 1'b1;
        wcyc(5);
        chk(dut_pull == 1'b0, "R1", "sda_pull idle", int'(dut_pull), 0);

        // R3: plain win, ACK from master
        dev = 7'h2A; stat = 1'b1; pend = 1'b1;
        run_txn(8'h19, 1'b0, 8'hFF, 1'b1, 1'b1, "R3 lone win");
        // R5: status bit both polarities
        stat = 1'b0;
        run_txn(8'h19, 1'b0, 8'hFF, 1'b0, 1'b1, "R5 status low");
        stat = 1'b1;
        run_txn(8'h19, 1'b0, 8'hFF, 1'b0, 1'b1, "R5 status high");
        // R2: no alert pending; wrong address (write bit)
        pend = 1'b0;
        run_txn(8'h19, 1'b0, 8'hFF, 1'b0, 1'b1, "R2 no alert");
        pend = 1'b1;
        run_txn(8'h18, 1'b0, 8'hFF, 1'b0, 1'b1, "R2 write bit");
        // R4: rival with lower address wins, then R7: repeated START without STOP
        dev = 7'h40;
        run_txn(8'h19, 1'b1, {7'h3F, 1'b1}, 1'b0, 1'b0, "R4 lose");
        run_txn(8'h19, 1'b0, 8'hFF, 1'b0, 1'b1, "R7 repeated start win");
        // R4: rival with higher address loses
        run_txn(8'h19, 1'b1, {7'h41, 1'b0}, 1'b0, 1'b1, "R4 beat rival");

        // R8: stall mid-transmission with SDA pulled
        dev = 7'h12; stat = 1'b0;
        begin
            bit ack;
            bus_start();
            send_byte(8'h19, ack);
            chk(ack, "R2", "R8 setup acknowledge", int'(ack), 1);
            wcyc(Q);
            chk(sda_line == 1'b0, "R3", "first response bit pulled low", int'(sda_line), 0);
            wcyc(TMO + 20);
            chk(sda_line == 1'b1, "R8", "SDA released after timeout", int'(sda_line), 1);
            bus_stop();
        end

        // R7: STOP in the middle of the address byte, then a fresh transfer
        begin
            bus_start();
            for (int i = 0; i < 4; i++) begin
                m_sda = 1'b0; wcyc(Q); scl = 1'b1; wcyc(H); scl = 1'b0; wcyc(Q);
            end
            bus_stop();
            chk(sda_line == 1'b1, "R7", "released after mid-byte STOP", int'(sda_line), 1);
            run_txn(8'h19, 1'b0, 8'hFF, 1'b1, 1'b1, "R7 after abort");
        end

        // randomized transfers
        for (int it = 0; it < 40; it++) begin
            logic [7:0] ab, rb;
            bit         rv;
            logic [6:0] ra;
            dev  = 7'($urandom % 128);
            stat = 1'($urandom % 2);
            pend = (($urandom % 5) != 0);
            ab   = (($urandom % 10) < 7) ? 8'h19 : 8'($urandom % 256);
            rv   = ($urandom % 2) == 1;
            ra   = 7'($urandom % 128);
            if (ra == dev) ra = ra ^ 7'h01;
            rb   = {ra, 1'($urandom % 2)};
            run_txn(ab, rv, rb, ($urandom % 2) == 1, 1'b1, "random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule